// File: doc/BRIEF.md
# Word-to-Byte Bus Width Bridge

This bridge sits between a master that issues 32-bit word transfers and a slave that moves one byte per access. The master presents a byte address, four byte-lane enables, a read or write strobe and a write word. It is held off by its wait signal while the bridge runs one byte access on the slave side for each enabled lane. Read bytes are packed into their lanes little-endian: lane 0, bits 7:0, holds the lowest byte address. Write bytes are taken from the matching lanes of the master word.

The controller has three states. In `ST_IDLE` it watches for a request. A request with no lane enabled is finished in the same cycle. A request with any lane enabled is latched, and the transition moves to `ST_BYTE`. `ST_BYTE` drives one slave access for the lowest pending lane. While the slave waits, it stays on that lane. When the slave completes, it advances to the next pending lane, or moves to `ST_REPLY` if none is left. `ST_REPLY` drops the master wait for one cycle, presents the assembled read word, and returns to `ST_IDLE`.

Both sides cover the same byte span. The slave uses all `ADDR_W` byte-address bits. The master's word address is its upper `ADDR_W-2` bits.

Top module: `word_byte_bridge`

## Requirements
- R1: Each enabled lane (bit i of `m_be` set) produces exactly one completed slave access, and a lane that is not enabled produces none; slave bytes of disabled lanes are left unchanged by a write.
- R2: Within one master transfer, slave accesses visit the enabled lanes in ascending lane order.
- R3: The slave address of lane i is `{m_addr[ADDR_W-1:2], i}`; the master's two lowest address bits are disregarded.
- R4: On a write, the slave data for lane i is `m_wdata[8i+7:8i]`.
- R5: On a read, the byte returned by the slave for lane i is placed in `m_rdata[8i+7:8i]` in the completion cycle.
- R6: On a read, lanes that are not enabled read as zero.
- R7: For a transfer with k>0 enabled lanes and a slave that holds `s_wait` for w cycles per access, `m_wait` is high for 1+k(1+w) cycles, and the transfer completes in the following cycle.
- R8: A request with `m_be` = 0 completes in its first cycle (`m_wait` low), issues no slave access, and a read returns zero.
- R9: While the slave asserts `s_wait` on an active access, `s_addr`, `s_wdata`, `s_read` and `s_write` remain unchanged into the next cycle.
- R10: `s_read` and `s_write` are never high together; a master write produces slave writes and a master read produces slave reads.
- R11: After reset, with no request, `m_wait`, `s_read` and `s_write` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | ADDR_W | Master byte address (word aligned) |
| m_be | input | 4 | Master byte-lane enables |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | 32 | Master write word |
| m_rdata | output | 32 | Master read word, valid when the transfer completes |
| m_wait | output | 1 | Master stall; the transfer completes in a requesting cycle where it is low |
| s_addr | output | ADDR_W | Slave byte address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_wdata | output | 8 | Slave write byte |
| s_rdata | input | 8 | Slave read byte, taken when the access completes |
| s_wait | input | 1 | Slave stall |

## Verification
The hardest situation to reach is a slave stall in the middle of a sparse lane pattern, such as lanes 0 and 3 only, with the bridge holding one lane while it still owes others. The bench sweeps all sixteen enable patterns, for both reads and writes, against a slave model whose stall length is set per transfer to 0, 1 or 2 cycles. Every pattern therefore meets a stall on every lane it visits. A monitor compares slave outputs across each stalled cycle. A logged trace of completed slave accesses is compared to the ascending lane order computed from the enables.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BYTE  = 2'd1,
        ST_REPLY = 2'd2
    } wbb_state_e;
endpackage

// File: rtl/wbb_first_lane.sv
module wbb_first_lane #(
    parameter int LANES = 4,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic [LW-1:0]    lane_idx,
    output logic             lane_any
);
    // lowest pending lane wins
    always_comb begin
        lane_idx = '0;
        lane_any = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                lane_idx = LW'(i);
                lane_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wbb_lane_pick.sv
module wbb_lane_pick #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int LW     = $clog2(LANES)
) (
    input  logic [LANES*BYTE_W-1:0] word_in,
    input  logic [LW-1:0]           lane_idx,
    output logic [BYTE_W-1:0]       byte_out
);
    always_comb byte_out = word_in[lane_idx*BYTE_W +: BYTE_W];
endmodule

// File: rtl/wbb_lane_pack.sv
module wbb_lane_pack #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int LW     = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    load,
    input  logic [LW-1:0]           lane_idx,
    input  logic [BYTE_W-1:0]       byte_in,
    output logic [LANES*BYTE_W-1:0] word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                lane_q <= '0;
            end else if (load && lane_idx == LW'(g)) begin
                lane_q <= byte_in;
            end
        end
        assign word_out[g*BYTE_W +: BYTE_W] = lane_q;
    end
endmodule

// File: rtl/word_byte_bridge.sv
module word_byte_bridge
    import wbb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       m_addr,
    input  logic [LANES-1:0]        m_be,
    input  logic                    m_read,
    input  logic                    m_write,
    input  logic [LANES*BYTE_W-1:0] m_wdata,
    output logic [LANES*BYTE_W-1:0] m_rdata,
    output logic                    m_wait,
    output logic [ADDR_W-1:0]       s_addr,
    output logic                    s_read,
    output logic                    s_write,
    output logic [BYTE_W-1:0]       s_wdata,
    input  logic [BYTE_W-1:0]       s_rdata,
    input  logic                    s_wait
);
    localparam int WORD_W = LANES * BYTE_W;
    localparam int LW     = $clog2(LANES);

    wbb_state_e               state_q, state_d;
    logic [LANES-1:0]         pend_q, pend_d;
    logic [ADDR_W-LW-1:0]     base_q;
    logic [WORD_W-1:0]        wdata_q;
    logic                     is_wr_q;
    logic [LW-1:0]            cur_lane;
    logic                     cur_any;
    logic [LANES-1:0]         cur_oh;
    logic [WORD_W-1:0]        packed_word;
    logic [BYTE_W-1:0]        picked_byte;
    logic                     req;
    logic                     start;
    logic                     byte_done;

    assign req       = m_read | m_write;
    assign start     = (state_q == ST_IDLE) && req && (|m_be);
    assign byte_done = (state_q == ST_BYTE) && !s_wait;
    assign cur_oh    = LANES'(1) << cur_lane;

    wbb_first_lane #(.LANES(LANES), .LW(LW)) u_first (
        .pending  (pend_q),
        .lane_idx (cur_lane),
        .lane_any (cur_any)
    );

    wbb_lane_pick #(.LANES(LANES), .BYTE_W(BYTE_W), .LW(LW)) u_pick (
        .word_in  (wdata_q),
        .lane_idx (cur_lane),
        .byte_out (picked_byte)
    );

    wbb_lane_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .LW(LW)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .load     (byte_done && !is_wr_q),
        .lane_idx (cur_lane),
        .byte_in  (s_rdata),
        .word_out (packed_word)
    );

    // next-state and pending-lane logic
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    pend_d  = m_be;
                    state_d = ST_BYTE;
                end
            end
            ST_BYTE: begin
                if (!s_wait) begin
                    pend_d = pend_q & ~cur_oh;
                    if ((pend_q & ~cur_oh) == '0) begin
                        state_d = ST_REPLY;
                    end
                end
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                pend_d  = '0;
            end
        endcase
    end

    // state register and transfer latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            base_q  <= '0;
            wdata_q <= '0;
            is_wr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (start) begin
                base_q  <= m_addr[ADDR_W-1:LW];
                wdata_q <= m_wdata;
                is_wr_q <= m_write;
            end
        end
    end

    // outputs
    always_comb begin
        m_wait  = 1'b0;
        m_rdata = '0;
        s_read  = 1'b0;
        s_write = 1'b0;
        s_addr  = {base_q, cur_lane};
        s_wdata = picked_byte;
        unique case (state_q)
            ST_IDLE:  m_wait = start;
            ST_BYTE: begin
                m_wait  = 1'b1;
                s_read  = cur_any && !is_wr_q;
                s_write = cur_any && is_wr_q;
            end
            ST_REPLY: begin
                if (!is_wr_q) m_rdata = packed_word;
            end
            default: m_wait = 1'b0;
        endcase
    end

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_read, s_write}));

    assert_hold_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read || s_write) && s_wait |=>
            $stable(s_addr) && $stable(s_wdata) && $stable({s_read, s_write}));

    assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read || s_write) && !s_wait |=>
            (!(s_read || s_write) || (s_addr[LW-1:0] > $past(s_addr[LW-1:0]))));

    assert_word_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read || s_write) |-> s_addr[ADDR_W-1:LW] == m_addr[ADDR_W-1:LW]);

    assert_stall_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read || s_write) |-> m_wait);

    assert_empty_be_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && req && (m_be == '0) |-> !m_wait ##1 !(s_read || s_write));
endmodule

// File: tb/word_byte_bridge_tb.sv
`timescale 1ns/1ps
module word_byte_bridge_tb;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [3:0]  m_be = '0;
    logic        m_read = 1'b0;
    logic        m_write = 1'b0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic        m_wait;
    logic [AW-1:0] s_addr;
    logic        s_read, s_write;
    logic [7:0]  s_wdata;
    logic [7:0]  s_rdata;
    logic        s_wait;

    int n_checks = 0;
    int n_fail   = 0;
    int wait_cfg = 0;
    int wcnt     = 0;

    logic [7:0]    mem     [1024];
    logic [7:0]    exp_mem [1024];
    logic [AW-1:0] log_addr [2048];
    logic [7:0]    log_data [2048];
    logic          log_wr   [2048];
    int log_n = 0;
    int stab_viol = 0;

    always #2.5 clk = ~clk;

    word_byte_bridge #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_addr(m_addr), .m_be(m_be), .m_read(m_read), .m_write(m_write),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_wait(m_wait),
        .s_addr(s_addr), .s_read(s_read), .s_write(s_write),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_wait(s_wait)
    );

    assign s_wait  = (s_read || s_write) && (wcnt < wait_cfg);
    assign s_rdata = mem[s_addr];

    // slave model with access log
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'((i * 7 + 3) & 255);
            wcnt <= 0;
        end else if (s_read || s_write) begin
            if (s_wait) begin
                wcnt <= wcnt + 1;
            end else begin
                wcnt <= 0;
                if (s_write) mem[s_addr] <= s_wdata;
                log_addr[log_n] <= s_addr;
                log_data[log_n] <= s_write ? s_wdata : s_rdata;
                log_wr[log_n]   <= s_write;
                log_n <= log_n + 1;
            end
        end
    end

    // stall stability monitor (R9)
    logic          p_act = 1'b0;
    logic [AW-1:0] p_addr;
    logic [7:0]    p_wd;
    logic [1:0]    p_str;
    always @(negedge clk) begin
        if (p_act && (s_addr != p_addr || s_wdata != p_wd || {s_read, s_write} != p_str))
            stab_viol <= stab_viol + 1;
        p_act  <= rst_n && (s_read || s_write) && s_wait;
        p_addr <= s_addr;
        p_wd   <= s_wdata;
        p_str  <= {s_read, s_write};
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_access(input logic [AW-1:0] addr, input logic [3:0] be,
                              input bit wr, input logic [31:0] wd, input int waits);
        int start_n, stab0, n, k, j;
        bit done, ok_addr, ok_data, ok_dir;
        logic [31:0] got, exp_word;
        logic [AW-1:0] base;
        wait_cfg = waits;
        start_n  = log_n;
        stab0    = stab_viol;
        m_addr = addr; m_be = be; m_write = wr; m_read = !wr; m_wdata = wd;
        n = 0; done = 0; got = '0;
        while (!done && n < 100) begin
            #1;
            n++;
            if (!m_wait) begin
                got = m_rdata;
                done = 1;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        m_read = 1'b0; m_write = 1'b0;
        k = $countones(be);
        base = {addr[AW-1:2], 2'b00};
        check(log_n - start_n == k, "R1 slave access count", 32'(log_n - start_n), 32'(k));
        ok_addr = 1; ok_data = 1; ok_dir = 1; j = start_n;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                if (j >= log_n || log_addr[j] != base + AW'(i)) ok_addr = 0;
                if (wr && j < log_n && log_data[j] != wd[8*i +: 8]) ok_data = 0;
                if (j < log_n && log_wr[j] != wr) ok_dir = 0;
                j++;
            end
        end
        check(ok_addr, "R2 R3 lane order and address", 32'(addr), 32'(be));
        check(ok_dir, "R10 access direction", 32'(wr), 32'(wr));
        check(stab_viol == stab0, "R9 hold during slave wait", 32'(stab_viol - stab0), 0);
        check(n == ((be == 0) ? 1 : 2 + k * (1 + waits)),
              (be == 0) ? "R8 empty enable latency" : "R7 master stall length",
              32'(n), 32'((be == 0) ? 1 : 2 + k * (1 + waits)));
        if (wr) begin
            check(ok_data, "R4 write lane data", wd, wd);
            for (int i = 0; i < 4; i++) if (be[i]) exp_mem[base + AW'(i)] = wd[8*i +: 8];
            for (int i = 0; i < 4; i++)
                check(mem[base + AW'(i)] == exp_mem[base + AW'(i)], "R1 R4 slave byte after write",
                      32'(mem[base + AW'(i)]), 32'(exp_mem[base + AW'(i)]));
        end else begin
            exp_word = '0;
            for (int i = 0; i < 4; i++) if (be[i]) exp_word[8*i +: 8] = exp_mem[base + AW'(i)];
            check(got == exp_word, (be == 0) ? "R8 empty read zero" : "R5 R6 read assembly",
                  got, exp_word);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'((i * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!m_wait && !s_read && !s_write, "R11 reset idle", {29'd0, m_wait, s_read, s_write}, 0);
        @(negedge clk);
        for (int w = 0; w < 3; w++) begin
            for (int b = 0; b < 16; b++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    int idx = w * 32 + b * 2 + wr;
                    logic [AW-1:0] a;
                    a = AW'(((idx * 37) % 256) * 4 + (idx % 4));
                    run_access(a, 4'(b), wr[0], 32'hA5000000 ^ 32'(idx * 32'h01030507), w);
                    run_access(a, 4'hF, 1'b0, 32'h0, 0);
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule